// File: doc/BRIEF.md
# Cell Access Instruction Unit

This unit sits next to one processor of a multiprocessor cellular simulation and acts as its instruction-extension slave for every cell access. The global cell array is split into equal slices. Each processor owns one slice, kept in a dual-port store that holds two generations of every cell. Each cell has a link field and a data field. The processor issues a function code, a global cell address and a write value. The unit completes the operation and returns a result word when it raises a done pulse.

The top bits of a global address name the owning processor, and the low bits index a cell inside that owner's slice. Reads always see the current generation and writes always land in the next one, so the cells stay consistent while all processors work on the same generation. Automatic reads compare the owner field with the unit's own identity. A match becomes a local memory read. Any other value becomes a request on the network port, and the processor stays stalled until the response word arrives. The second memory port is read-only and serves reads from other processors on the current generation. A next-generation instruction raises a ready flag and waits until every processor is ready. All units then flip their bank select in the same cycle.

Top module: `cell_access_unit`

## Requirements
- R1: During reset and in the first cycle after it, `ci_done`, `net_req_valid` and `sync_ready` are low. Bank 0 is the current generation.
- R2: The function codes are 0 auto link read, 1 auto data read, 2 local link read, 3 local data read, 4 shifted link write, 5 link write, 6 network link read, 7 data write, 8 network data read and 9 next-generation barrier. Codes 10 to 15 complete one cycle after acceptance with result zero, make no network request and change no cell.
- R3: Data and link writes (codes 7, 5) store into the next-generation bank at local index `ci_addr[IDX_W-1:0]`. They complete one cycle after acceptance with result zero, and their values stay invisible to reads until the next barrier completes.
- R4: Local reads (codes 2, 3) return the current-generation field of cell `ci_addr[IDX_W-1:0]`, zero-extended. They complete one cycle after acceptance whatever the owner bits of the address hold.
- R5: The shifted link write (code 4) stores bits `LINK_W:1` of the write value, which is the value shifted right by one position.
- R6: An auto read whose owner field `ci_addr[ADDR_W-1:IDX_W]` equals `unit_id` behaves exactly like the matching local read, with the same one-cycle latency and no network request.
- R7: An auto read with any other owner field pulses `net_req_valid` for one cycle, one cycle after acceptance. The pulse carries the full address and `net_req_link` high for a link read. `ci_done` rises one cycle after `net_rsp_valid` is sampled, and `ci_result` equals `net_rsp_word`.
- R8: Network reads (codes 6, 8) always use the network port as in R7, even when the owner field equals `unit_id`.
- R9: The barrier (code 9) raises `sync_ready` one cycle after acceptance and holds it until all bits of `peer_ready` are high. In the cycle after that condition is sampled, the bank select has flipped, `sync_ready` is low and `ci_done` pulses with result zero.
- R10: With `srv_rd_en` high, `srv_link` and `srv_data` show the current-generation fields of cell `srv_rd_idx` one cycle later. They are unaffected by writes to the next generation.
- R11: A `ci_start` that arrives while an instruction is still in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_id | input | ID_W | Identity of this processor |
| ci_start | input | 1 | Instruction start strobe |
| ci_func | input | 4 | Function code |
| ci_addr | input | ADDR_W | Global cell address |
| ci_wval | input | WORD_W | Write value |
| ci_done | output | 1 | One-cycle completion pulse |
| ci_result | output | WORD_W | Result word, valid with `ci_done` |
| net_req_valid | output | 1 | Network read request pulse |
| net_req_addr | output | ADDR_W | Requested global address |
| net_req_link | output | 1 | High for a link read, low for a data read |
| net_rsp_valid | input | 1 | Network response strobe |
| net_rsp_word | input | WORD_W | Network response word |
| srv_rd_en | input | 1 | Read enable on the serving port |
| srv_rd_idx | input | IDX_W | Local cell index on the serving port |
| srv_link | output | LINK_W | Served link field |
| srv_data | output | DATA_W | Served data field |
| sync_ready | output | 1 | This unit waits at the barrier |
| peer_ready | input | NUM_PU | Ready flags of all processors, own included |

## Verification
The bench builds the unit with four processors, eight cells per slice, 12-bit fields and a 16-bit result word, which gives a 32-cell global space. With this configuration, every address can be swept through every read function under every one of the four unit identities. That sweep covers each owner match and mismatch, and it shows that local reads ignore the owner bits. Small slices also let the bench refill and compare whole banks across barriers, including barriers where release is delayed. The same refills make it possible to confirm that ignored starts and undefined codes leave every cell untouched.

// File: rtl/cau_pkg.sv
`timescale 1ns/1ps
package cau_pkg;

  localparam logic [3:0] FN_AUTO_LINK    = 4'd0;
  localparam logic [3:0] FN_AUTO_DATA    = 4'd1;
  localparam logic [3:0] FN_LOC_LINK     = 4'd2;
  localparam logic [3:0] FN_LOC_DATA     = 4'd3;
  localparam logic [3:0] FN_SET_LINK_SHR = 4'd4;
  localparam logic [3:0] FN_SET_LINK     = 4'd5;
  localparam logic [3:0] FN_EXT_LINK     = 4'd6;
  localparam logic [3:0] FN_SET_DATA     = 4'd7;
  localparam logic [3:0] FN_EXT_DATA     = 4'd8;
  localparam logic [3:0] FN_SYNC         = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NET  = 2'd1,
    ST_SYNC = 2'd2
  } cau_state_e;

  typedef struct packed {
    logic known;
    logic is_link;
    logic rd_local;
    logic rd_remote;
    logic wr;
    logic shr;
    logic sync;
  } cau_op_t;

endpackage

// File: rtl/cau_func_decode.sv
`timescale 1ns/1ps
module cau_func_decode
  import cau_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic [3:0]      func,
  input  logic [ID_W-1:0] addr_id,
  input  logic [ID_W-1:0] own_id,
  output cau_op_t         op
);

  logic id_hit;

  always_comb begin
    id_hit = (addr_id == own_id);
    op = '0;
    op.known = 1'b1;
    case (func)
      FN_AUTO_LINK: begin
        op.is_link   = 1'b1;
        op.rd_local  = id_hit;
        op.rd_remote = !id_hit;
      end
      FN_AUTO_DATA: begin
        op.rd_local  = id_hit;
        op.rd_remote = !id_hit;
      end
      FN_LOC_LINK: begin
        op.is_link  = 1'b1;
        op.rd_local = 1'b1;
      end
      FN_LOC_DATA: op.rd_local = 1'b1;
      FN_SET_LINK_SHR: begin
        op.is_link = 1'b1;
        op.wr      = 1'b1;
        op.shr     = 1'b1;
      end
      FN_SET_LINK: begin
        op.is_link = 1'b1;
        op.wr      = 1'b1;
      end
      FN_EXT_LINK: begin
        op.is_link   = 1'b1;
        op.rd_remote = 1'b1;
      end
      FN_SET_DATA: op.wr        = 1'b1;
      FN_EXT_DATA: op.rd_remote = 1'b1;
      FN_SYNC:     op.sync      = 1'b1;
      default:     op.known     = 1'b0;
    endcase
  end

endmodule

// File: rtl/cau_bank_ram.sv
`timescale 1ns/1ps
module cau_bank_ram #(
  parameter int WIDTH = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [IDX_W:0]   a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  input  logic             b_en,
  input  logic [IDX_W:0]   b_addr,
  output logic [WIDTH-1:0] b_rdata
);

  localparam int DEPTH = 2 ** (IDX_W + 1);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) begin
        mem[a_addr] <= a_wdata;
      end else begin
        a_rdata <= mem[a_addr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (b_en) begin
      b_rdata <= mem[b_addr];
    end
  end

endmodule

// File: rtl/cau_barrier.sv
`timescale 1ns/1ps
module cau_barrier #(
  parameter int NUM_PU = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [NUM_PU-1:0] peer_ready,
  output logic              ready_o,
  output logic              fire_o,
  output logic              bank_o
);

  logic ready_q;
  logic bank_q;

  assign fire_o  = ready_q & (&peer_ready);
  assign ready_o = ready_q;
  assign bank_o  = bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      bank_q  <= 1'b0;
    end else if (arm) begin
      ready_q <= 1'b1;
    end else if (fire_o) begin
      ready_q <= 1'b0;
      bank_q  <= ~bank_q;
    end
  end

  assert_bank_flip_on_release_R9: assert property (@(posedge clk) disable iff (rst)
    (bank_q != $past(bank_q)) |-> $past(ready_q && (&peer_ready)));

  assert_ready_drops_after_release_R9: assert property (@(posedge clk) disable iff (rst)
    (ready_q && (&peer_ready)) |=> !ready_q);

  assert_ready_rises_on_arm_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(arm));

endmodule

// File: rtl/cell_access_unit.sv
`timescale 1ns/1ps
module cell_access_unit
  import cau_pkg::*;
#(
  parameter int NUM_PU = 8,
  parameter int IDX_W  = 8,
  parameter int LINK_W = 16,
  parameter int DATA_W = 16,
  parameter int WORD_W = 32,
  localparam int ID_W   = $clog2(NUM_PU),
  localparam int ADDR_W = ID_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   unit_id,
  input  logic              ci_start,
  input  logic [3:0]        ci_func,
  input  logic [ADDR_W-1:0] ci_addr,
  input  logic [WORD_W-1:0] ci_wval,
  output logic              ci_done,
  output logic [WORD_W-1:0] ci_result,
  output logic              net_req_valid,
  output logic [ADDR_W-1:0] net_req_addr,
  output logic              net_req_link,
  input  logic              net_rsp_valid,
  input  logic [WORD_W-1:0] net_rsp_word,
  input  logic              srv_rd_en,
  input  logic [IDX_W-1:0]  srv_rd_idx,
  output logic [LINK_W-1:0] srv_link,
  output logic [DATA_W-1:0] srv_data,
  output logic              sync_ready,
  input  logic [NUM_PU-1:0] peer_ready
);

  cau_state_e        state_q;
  cau_op_t           op;
  logic              accept;
  logic              bank;
  logic              fire;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W:0]    a_addr;
  logic [IDX_W:0]    b_addr;
  logic              link_en, link_we, data_en, data_we;
  logic [WORD_W-1:0] link_full;
  logic [LINK_W-1:0] link_wdata;
  logic [DATA_W-1:0] data_wdata;
  logic [LINK_W-1:0] link_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q, req_valid_q, req_link_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              res_mem_q, res_link_q;
  logic [WORD_W-1:0] res_q;
  logic              unused_wval;

  assign unused_wval = ^ci_wval;

  cau_func_decode #(.ID_W(ID_W)) u_decode (
    .func    (ci_func),
    .addr_id (ci_addr[ADDR_W-1:IDX_W]),
    .own_id  (unit_id),
    .op      (op)
  );

  assign accept = ci_start && (state_q == ST_IDLE);
  assign idx    = ci_addr[IDX_W-1:0];

  // Reads use the current bank, writes the other one.
  assign a_addr = {(op.wr ? ~bank : bank), idx};
  assign b_addr = {bank, srv_rd_idx};

  assign link_we = accept && op.wr && op.is_link;
  assign data_we = accept && op.wr && !op.is_link;
  assign link_en = accept && op.is_link && (op.rd_local || op.wr);
  assign data_en = accept && !op.is_link && (op.rd_local || op.wr);

  assign link_full  = op.shr ? (ci_wval >> 1) : ci_wval;
  assign link_wdata = link_full[LINK_W-1:0];
  assign data_wdata = ci_wval[DATA_W-1:0];

  cau_bank_ram #(.WIDTH(LINK_W), .IDX_W(IDX_W)) u_link_ram (
    .clk     (clk),
    .a_en    (link_en),
    .a_we    (link_we),
    .a_addr  (a_addr),
    .a_wdata (link_wdata),
    .a_rdata (link_q),
    .b_en    (srv_rd_en),
    .b_addr  (b_addr),
    .b_rdata (srv_link)
  );

  cau_bank_ram #(.WIDTH(DATA_W), .IDX_W(IDX_W)) u_data_ram (
    .clk     (clk),
    .a_en    (data_en),
    .a_we    (data_we),
    .a_addr  (a_addr),
    .a_wdata (data_wdata),
    .a_rdata (data_q),
    .b_en    (srv_rd_en),
    .b_addr  (b_addr),
    .b_rdata (srv_data)
  );

  cau_barrier #(.NUM_PU(NUM_PU)) u_barrier (
    .clk        (clk),
    .rst        (rst),
    .arm        (accept && op.sync),
    .peer_ready (peer_ready),
    .ready_o    (sync_ready),
    .fire_o     (fire),
    .bank_o     (bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      done_q      <= 1'b0;
      req_valid_q <= 1'b0;
      req_link_q  <= 1'b0;
      req_addr_q  <= '0;
      res_mem_q   <= 1'b0;
      res_link_q  <= 1'b0;
      res_q       <= '0;
    end else begin
      done_q      <= 1'b0;
      req_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ci_start) begin
            if (!op.known || op.wr) begin
              done_q    <= 1'b1;
              res_mem_q <= 1'b0;
              res_q     <= '0;
            end else if (op.rd_local) begin
              done_q     <= 1'b1;
              res_mem_q  <= 1'b1;
              res_link_q <= op.is_link;
            end else if (op.rd_remote) begin
              req_valid_q <= 1'b1;
              req_addr_q  <= ci_addr;
              req_link_q  <= op.is_link;
              state_q     <= ST_NET;
            end else begin
              state_q <= ST_SYNC;
            end
          end
        end
        ST_NET: begin
          if (net_rsp_valid) begin
            done_q    <= 1'b1;
            res_mem_q <= 1'b0;
            res_q     <= net_rsp_word;
            state_q   <= ST_IDLE;
          end
        end
        ST_SYNC: begin
          if (fire) begin
            done_q    <= 1'b1;
            res_mem_q <= 1'b0;
            res_q     <= '0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ci_result = res_q;
    if (res_mem_q) begin
      ci_result = '0;
      if (res_link_q) ci_result[LINK_W-1:0] = link_q;
      else            ci_result[DATA_W-1:0] = data_q;
    end
  end

  assign ci_done       = done_q;
  assign net_req_valid = req_valid_q;
  assign net_req_addr  = req_addr_q;
  assign net_req_link  = req_link_q;

  assert_single_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    ci_done |=> !ci_done);

  assert_local_hit_no_net_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && op.rd_local) |=> (ci_done && !net_req_valid));

  assert_remote_issues_req_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && op.rd_remote) |=> (net_req_valid && !ci_done));

  assert_req_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    net_req_valid |=> !net_req_valid);

  assert_busy_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> !(link_we || data_we));

endmodule

// File: tb/cell_access_unit_tb.sv
`timescale 1ns/1ps
module cell_access_unit_tb;
  import cau_pkg::*;

  localparam int NPU   = 4;
  localparam int CELLS = 8;
  localparam int RD    = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  unit_id = 2'd2;
  logic        ci_start = 1'b0;
  logic [3:0]  ci_func = 4'd0;
  logic [4:0]  ci_addr = 5'd0;
  logic [15:0] ci_wval = 16'd0;
  logic        ci_done;
  logic [15:0] ci_result;
  logic        net_req_valid;
  logic [4:0]  net_req_addr;
  logic        net_req_link;
  logic        net_rsp_valid = 1'b0;
  logic [15:0] net_rsp_word = 16'd0;
  logic        srv_rd_en = 1'b0;
  logic [2:0]  srv_rd_idx = 3'd0;
  logic [11:0] srv_link;
  logic [11:0] srv_data;
  logic        sync_ready;
  logic [3:0]  others = 4'd0;
  logic [3:0]  peer_ready;

  assign peer_ready = others | (4'(sync_ready) << unit_id);

  always #2.5 clk = ~clk;

  cell_access_unit #(.NUM_PU(NPU), .IDX_W(3), .LINK_W(12), .DATA_W(12), .WORD_W(16)) u_dut (
    .clk(clk), .rst(rst), .unit_id(unit_id),
    .ci_start(ci_start), .ci_func(ci_func), .ci_addr(ci_addr), .ci_wval(ci_wval),
    .ci_done(ci_done), .ci_result(ci_result),
    .net_req_valid(net_req_valid), .net_req_addr(net_req_addr), .net_req_link(net_req_link),
    .net_rsp_valid(net_rsp_valid), .net_rsp_word(net_rsp_word),
    .srv_rd_en(srv_rd_en), .srv_rd_idx(srv_rd_idx), .srv_link(srv_link), .srv_data(srv_data),
    .sync_ready(sync_ready), .peer_ready(peer_ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_req = 0;
  logic [4:0] last_addr;
  logic       last_link;

  logic [11:0] m_cur_l [CELLS];
  logic [11:0] m_cur_d [CELLS];
  logic [11:0] m_nxt_l [CELLS];
  logic [11:0] m_nxt_d [CELLS];

  function automatic logic [11:0] pat(int seed, int i, bit lnk);
    return 12'(seed * 389 + i * 73 + (lnk ? 1021 : 0));
  endfunction

  function automatic logic [15:0] rsp_fn(logic [4:0] a, logic l);
    return {1'b0, l, 9'd0, a};
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] f, input logic [4:0] a, input logic [15:0] w,
                       output logic [15:0] res, output int lat);
    @(negedge clk);
    ci_func = f; ci_addr = a; ci_wval = w; ci_start = 1'b1;
    @(negedge clk);
    ci_start = 1'b0;
    lat = 1;
    while (!ci_done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    res = ci_result;
  endtask

  task automatic swap_model();
    for (int i = 0; i < CELLS; i++) begin
      logic [11:0] tl, td;
      tl = m_cur_l[i]; td = m_cur_d[i];
      m_cur_l[i] = m_nxt_l[i]; m_cur_d[i] = m_nxt_d[i];
      m_nxt_l[i] = tl; m_nxt_d[i] = td;
    end
  endtask

  task automatic do_sync();
    logic [15:0] r; int lat;
    others = 4'hF;
    do_op(FN_SYNC, 5'd0, 16'd0, r, lat);
    chk("R9", "sync latency", 32'(lat), 32'd2);
    chk("R9", "sync result", 32'(r), 32'd0);
    others = 4'h0;
    swap_model();
  endtask

  task automatic write_all(input int seed);
    logic [15:0] r; int lat;
    for (int i = 0; i < CELLS; i++) begin
      do_op(FN_SET_DATA, {unit_id, 3'(i)}, 16'(pat(seed, i, 0)) | 16'hF000, r, lat);
      chk("R3", "data write latency", 32'(lat), 32'd1);
      chk("R3", "data write result", 32'(r), 32'd0);
      m_nxt_d[i] = pat(seed, i, 0);
      do_op(FN_SET_LINK, {unit_id, 3'(i)}, 16'(pat(seed, i, 1)), r, lat);
      chk("R3", "link write latency", 32'(lat), 32'd1);
      m_nxt_l[i] = pat(seed, i, 1);
    end
  endtask

  task automatic read_all_local(input string rq);
    logic [15:0] r; int lat;
    for (int a = 0; a < 32; a++) begin
      do_op(FN_LOC_LINK, 5'(a), 16'd0, r, lat);
      chk(rq, "local link read", 32'(r), 32'(m_cur_l[a % CELLS]));
      chk("R4", "local link latency", 32'(lat), 32'd1);
      do_op(FN_LOC_DATA, 5'(a), 16'd0, r, lat);
      chk(rq, "local data read", 32'(r), 32'(m_cur_d[a % CELLS]));
      chk("R4", "local data latency", 32'(lat), 32'd1);
    end
  endtask

  task automatic srv_read(input int i);
    @(negedge clk);
    srv_rd_en = 1'b1; srv_rd_idx = 3'(i);
    @(negedge clk);
    srv_rd_en = 1'b0;
    chk("R10", "served link", 32'(srv_link), 32'(m_cur_l[i]));
    chk("R10", "served data", 32'(srv_data), 32'(m_cur_d[i]));
  endtask

  initial begin : responder
    forever begin
      @(negedge clk);
      if (net_req_valid) begin
        last_addr = net_req_addr;
        last_link = net_req_link;
        n_req++;
        repeat (RD - 1) @(negedge clk);
        net_rsp_valid = 1'b1;
        net_rsp_word  = rsp_fn(last_addr, last_link);
        @(negedge clk);
        net_rsp_valid = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    int lat, n0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "done in reset", 32'(ci_done), 32'd0);
    chk("R1", "req in reset", 32'(net_req_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", 32'(ci_done), 32'd0);
    chk("R1", "req after reset", 32'(net_req_valid), 32'd0);
    chk("R1", "ready after reset", 32'(sync_ready), 32'd0);

    // R3: writes go to the next bank, only visible after a barrier
    write_all(1);
    do_sync();
    write_all(2);
    read_all_local("R3");
    do_sync();
    read_all_local("R3");

    // R10: serving port on the current bank, blind to next-bank writes
    for (int i = 0; i < CELLS; i++) begin
      srv_read(i);
      do_op(FN_SET_DATA, {unit_id, 3'(i)}, 16'(pat(3, i, 0)), r, lat);
      m_nxt_d[i] = pat(3, i, 0);
      srv_read(i);
    end

    // R5: shifted link write
    for (int i = 0; i < CELLS; i++) begin
      logic [15:0] w;
      w = 16'(i * 9157 + 123);
      do_op(FN_SET_LINK_SHR, {unit_id, 3'(i)}, w, r, lat);
      chk("R5", "shift write latency", 32'(lat), 32'd1);
      m_nxt_l[i] = 12'(w >> 1);
    end
    do_sync();
    for (int i = 0; i < CELLS; i++) begin
      do_op(FN_LOC_LINK, {unit_id, 3'(i)}, 16'd0, r, lat);
      chk("R5", "shifted link", 32'(r), 32'(m_cur_l[i]));
    end

    // R6 / R7: auto routing under every identity
    for (int u = 0; u < NPU; u++) begin
      unit_id = 2'(u);
      for (int a = 0; a < 32; a++) begin
        for (int k = 0; k < 2; k++) begin
          logic lnk;
          lnk = (k == 0);
          n0 = n_req;
          do_op(lnk ? FN_AUTO_LINK : FN_AUTO_DATA, 5'(a), 16'd0, r, lat);
          if ((a / CELLS) == u) begin
            chk("R6", "auto local value", 32'(r),
                32'(lnk ? m_cur_l[a % CELLS] : m_cur_d[a % CELLS]));
            chk("R6", "auto local latency", 32'(lat), 32'd1);
            chk("R6", "auto local requests", 32'(n_req - n0), 32'd0);
          end else begin
            chk("R7", "auto remote value", 32'(r), 32'(rsp_fn(5'(a), lnk)));
            chk("R7", "auto remote latency", 32'(lat), 32'(RD + 1));
            chk("R7", "auto remote requests", 32'(n_req - n0), 32'd1);
            chk("R7", "request address", 32'(last_addr), 32'(a));
            chk("R7", "request field", 32'(last_link), 32'(lnk));
          end
        end
      end
    end

    // R8: network reads always go out
    unit_id = 2'd1;
    for (int a = 0; a < 32; a++) begin
      n0 = n_req;
      do_op(FN_EXT_LINK, 5'(a), 16'd0, r, lat);
      chk("R8", "ext link value", 32'(r), 32'(rsp_fn(5'(a), 1'b1)));
      chk("R8", "ext link requests", 32'(n_req - n0), 32'd1);
      do_op(FN_EXT_DATA, 5'(a), 16'd0, r, lat);
      chk("R8", "ext data value", 32'(r), 32'(rsp_fn(5'(a), 1'b0)));
      chk("R8", "ext data latency", 32'(lat), 32'(RD + 1));
    end

    // R11: start during a network wait is ignored
    unit_id = 2'd2;
    fork
      begin
        do_op(FN_EXT_DATA, 5'd0, 16'd0, r, lat);
      end
      begin
        repeat (3) @(negedge clk);
        ci_func = FN_SET_DATA; ci_addr = {2'd2, 3'd0}; ci_wval = 16'h0ABC; ci_start = 1'b1;
        @(negedge clk);
        ci_start = 1'b0;
      end
    join
    chk("R11", "ext result while busy", 32'(r), 32'(rsp_fn(5'd0, 1'b0)));
    @(negedge clk);
    chk("R11", "no extra done", 32'(ci_done), 32'd0);
    do_sync();
    do_op(FN_LOC_DATA, {2'd2, 3'd0}, 16'd0, r, lat);
    chk("R11", "ignored write absent", 32'(r), 32'(m_cur_d[0]));

    // R9: delayed release of the barrier
    fork
      begin
        do_op(FN_SYNC, 5'd0, 16'd0, r, lat);
      end
      begin
        repeat (2) @(negedge clk);
        chk("R9", "ready raised", 32'(sync_ready), 32'd1);
        repeat (3) @(negedge clk);
        chk("R9", "ready held", 32'(sync_ready), 32'd1);
        chk("R9", "no done before release", 32'(ci_done), 32'd0);
        others = 4'hF;
      end
    join
    others = 4'h0;
    swap_model();
    chk("R9", "delayed sync latency", 32'(lat), 32'd5);
    chk("R9", "ready dropped", 32'(sync_ready), 32'd0);
    read_all_local("R9");

    // R2: undefined codes do nothing
    for (int f = 10; f < 16; f++) begin
      for (int i = 0; i < CELLS; i++) begin
        n0 = n_req;
        do_op(4'(f), {unit_id, 3'(i)}, 16'hFFFF, r, lat);
        chk("R2", "undefined result", 32'(r), 32'd0);
        chk("R2", "undefined latency", 32'(lat), 32'd1);
        chk("R2", "undefined requests", 32'(n_req - n0), 32'd0);
      end
    end
    read_all_local("R2");
    do_sync();
    read_all_local("R2");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule